// File: doc/BRIEF.md
# Chainable Decimal Up/Down Decade Counter

This block holds one decimal digit and steps it by one on each rising clock edge, upward or downward as a direction input selects. Counting is gated by an active-low enable. Two inputs act without the clock. An active-high clear forces the digit to zero. An active-high preset makes the digit take a 4-bit value driven from outside for as long as that input is high. The clear wins over the preset, and both win over counting.

An active-low terminal flag is decoded combinationally from the current digit, the direction and the enable. It goes low on the digit that will wrap at the next edge: nine when counting up, zero when counting down. It only does so while the enable is low. Several decades share one clock, and each decade's flag drives the enable of the next higher decade, so a multi-digit counter stays fully synchronous.

The register that holds the digit captures the preset value when the preset input rises and again on every clock edge while the preset input stays high. The preset value must therefore be stable when the preset input falls, unless a clock edge occurred after its last change.

Top module: `bcd_updown_decade`

## Requirements
- R1: While `clr_i` is high, `digit_o` is 0 at once, without waiting for a clock edge, whatever `load_i`, `pval_i`, `hold_n_i`, `up_i` and `clk_i` do. The first clock edge after `clr_i` falls with `load_i` low sees the digit still at 0.
- R2: While `load_i` is high and `clr_i` is low, `digit_o` equals `pval_i` without waiting for a clock edge. After `load_i` falls, the last preset value stays in place.
- R3: With `clr_i`, `load_i` and `hold_n_i` low, `digit_o` changes only on a rising edge of `clk_i`. It does not change between edges.
- R4: With `clr_i` and `load_i` low and `hold_n_i` high, `digit_o` keeps its value across clock edges.
- R5: With `up_i` high (up direction), each counting edge adds one to the digit, and 9 goes to 0.
- R6: With `up_i` low (down direction), each counting edge subtracts one from the digit, and 0 goes to 9.
- R7: A digit from 10 to 15, which can only come from a preset, goes to 0 on an up edge. On a down edge it goes to the value one lower.
- R8: In the up direction, `tc_n_o` is low exactly when `hold_n_i` is low and bits 0 and 3 of `digit_o` are both high. It is therefore also low at 11, 13 and 15.
- R9: In the down direction, `tc_n_o` is low exactly when `hold_n_i` is low and `digit_o` is 0. In every other case `tc_n_o` is high.
- R10: `tc_n_o` is combinational and not registered. When one decade's `tc_n_o` drives the `hold_n_i` of a second decade on the same clock, the pair counts 00 to 99 and wraps to 00 going up, and counts from 99 back to 00 going down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock, rising edge |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| hold_n_i | input | 1 | Count enable, active low |
| load_i | input | 1 | Asynchronous preset, active high, level sensitive |
| pval_i | input | 4 | Preset value |
| clr_i | input | 1 | Asynchronous clear, active high, highest priority |
| digit_o | output | 4 | Current digit |
| tc_n_o | output | 1 | Terminal flag, active low, combinational |

## Verification
The hardest cases to reach are the ones that happen between clock edges. These are the preset following a changing value, the clear overriding an active preset, and the preset input falling with no edge after it. The bench changes these inputs half a nanosecond after a falling edge and samples shortly afterwards, well before the next rising edge. The illegal digits 10 to 15 can be reached only through the preset, so the bench loads 13 and 12 and then counts away from them. The chained pair is run up through all hundred states and back, so the low decade's flag must open the high decade's enable at exactly the right edges.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } count_dir_e;

    localparam int unsigned DECADE_MODULUS = 10;

endpackage

// File: rtl/bcd_step_logic.sv
module bcd_step_logic #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         hold_n_i,
    output logic [W-1:0] nxt_o
);
    import bcd_cnt_pkg::*;

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);
    localparam logic [W-1:0] ONE  = W'(1);

    count_dir_e dir;

    always_comb begin
        dir   = count_dir_e'(up_i);
        nxt_o = cur_i;
        if (!hold_n_i) begin
            if (dir == DIR_UP) begin
                // values at or beyond the last legal digit fall back to zero
                nxt_o = (cur_i >= LAST) ? '0 : cur_i + ONE;
            end else begin
                nxt_o = (cur_i == '0) ? LAST : cur_i - ONE;
            end
        end
    end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         hold_n_i,
    output logic         tc_n_o
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    logic top_hit;
    logic bottom_hit;

    generate
        if (MODULUS == 10 && W == 4) begin : g_sparse
            // nine is the only legal digit with bits 0 and 3 both set
            assign top_hit = cur_i[0] & cur_i[3];
        end else begin : g_full
            assign top_hit = (cur_i == LAST);
        end
    endgenerate

    assign bottom_hit = (cur_i == '0);

    always_comb begin
        tc_n_o = 1'b1;
        if (!hold_n_i) begin
            tc_n_o = up_i ? ~top_hit : ~bottom_hit;
        end
    end
endmodule

// File: rtl/bcd_updown_decade.sv
module bcd_updown_decade #(
    parameter int unsigned MODULUS = bcd_cnt_pkg::DECADE_MODULUS,
    parameter int unsigned W       = $clog2(MODULUS)
) (
    input  logic         clk_i,
    input  logic         up_i,
    input  logic         hold_n_i,
    input  logic         load_i,
    input  logic [W-1:0] pval_i,
    input  logic         clr_i,
    output logic [W-1:0] digit_o,
    output logic         tc_n_o
);
    typedef struct packed {
        logic [W-1:0] digit;
    } decade_state_t;

    decade_state_t state_d;
    decade_state_t state_q;
    logic [W-1:0]  step_nxt;

    bcd_step_logic #(.MODULUS(MODULUS), .W(W)) u_step (
        .cur_i    (state_q.digit),
        .up_i     (up_i),
        .hold_n_i (hold_n_i),
        .nxt_o    (step_nxt)
    );

    always_comb begin
        state_d       = state_q;
        state_d.digit = step_nxt;
    end

    always_ff @(posedge clk_i or posedge clr_i or posedge load_i) begin
        if (clr_i) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q.digit <= pval_i;
        end else begin
            state_q <= state_d;
        end
    end

    // level-sensitive override so the output tracks the preset while it is held
    always_comb begin
        if (clr_i) begin
            digit_o = '0;
        end else if (load_i) begin
            digit_o = pval_i;
        end else begin
            digit_o = state_q.digit;
        end
    end

    bcd_tc_decode #(.MODULUS(MODULUS), .W(W)) u_tc (
        .cur_i    (digit_o),
        .up_i     (up_i),
        .hold_n_i (hold_n_i),
        .tc_n_o   (tc_n_o)
    );
endmodule

// File: rtl/bcd_updown_decade_chk.sv
module bcd_updown_decade_chk #(
    parameter int unsigned MODULUS = 10,
    parameter int unsigned W       = 4
) (
    input logic         clk_i,
    input logic         up_i,
    input logic         hold_n_i,
    input logic         load_i,
    input logic [W-1:0] pval_i,
    input logic         clr_i,
    input logic [W-1:0] digit_o,
    input logic         tc_n_o
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    AST_CLEAR_LEAVES_ZERO: assert property (@(posedge clk_i) disable iff (clr_i)
        ($fell(clr_i) && !load_i) |-> (digit_o == '0)); // R1

    AST_PRESET_KEPT: assert property (@(posedge clk_i) disable iff (clr_i)
        ($fell(load_i) && $stable(pval_i)) |-> (digit_o == $past(pval_i))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (clr_i)
        (!load_i && hold_n_i) |=> (load_i || $stable(digit_o))); // R4

    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (clr_i)
        (!load_i && !hold_n_i && up_i && digit_o < LAST) |=> (load_i || digit_o == $past(digit_o) + W'(1))); // R5

    AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (clr_i)
        (!load_i && !hold_n_i && up_i && digit_o == LAST) |=> (load_i || digit_o == '0)); // R5

    AST_DOWN_WRAP: assert property (@(posedge clk_i) disable iff (clr_i)
        (!load_i && !hold_n_i && !up_i && digit_o == '0) |=> (load_i || digit_o == LAST)); // R6

    AST_TC_GATED: assert property (@(posedge clk_i) disable iff (clr_i)
        hold_n_i |-> tc_n_o); // R9

    AST_TC_DOWN_ZERO: assert property (@(posedge clk_i) disable iff (clr_i)
        (!hold_n_i && !up_i) |-> (tc_n_o == (digit_o != '0))); // R9
endmodule

bind bcd_updown_decade bcd_updown_decade_chk #(.MODULUS(MODULUS), .W(W)) u_chk (
    .clk_i    (clk_i),
    .up_i     (up_i),
    .hold_n_i (hold_n_i),
    .load_i   (load_i),
    .pval_i   (pval_i),
    .clr_i    (clr_i),
    .digit_o  (digit_o),
    .tc_n_o   (tc_n_o)
);

// File: tb/tb_bcd_updown_decade.sv
`timescale 1ns/1ps
module tb_bcd_updown_decade;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       load = 1'b0;
    logic       up = 1'b1;
    logic       hold_n = 1'b1;
    logic [3:0] pval = 4'd0;
    logic [3:0] hi_pval = 4'd0;
    logic [3:0] lo_digit;
    logic [3:0] hi_digit;
    logic       lo_tc_n;
    logic       hi_tc_n;

    int    n_chk = 0;
    int    n_bad = 0;
    int    m_lo = 0;
    int    m_hi = 0;
    bit    cmp_on = 1'b0;
    bit    finished = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    bcd_updown_decade dut (
        .clk_i(clk), .up_i(up), .hold_n_i(hold_n), .load_i(load),
        .pval_i(pval), .clr_i(clr), .digit_o(lo_digit), .tc_n_o(lo_tc_n)
    );

    bcd_updown_decade dut_hi (
        .clk_i(clk), .up_i(up), .hold_n_i(lo_tc_n), .load_i(load),
        .pval_i(hi_pval), .clr_i(clr), .digit_o(hi_digit), .tc_n_o(hi_tc_n)
    );

    function automatic int step(int v, bit dir_up);
        if (dir_up) return (v >= 9) ? 0 : v + 1;
        return (v == 0) ? 9 : v - 1;
    endfunction

    function automatic int shown(int v, int pv);
        if (clr) return 0;
        if (load) return pv;
        return v;
    endfunction

    function automatic bit tc_exp(int v, bit dir_up, bit en_n);
        if (en_n) return 1'b1;
        if (dir_up) return !(v == 9 || v == 11 || v == 13 || v == 15);
        return !(v == 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // reference model, advanced on the same edges as the design
    always @(posedge clk) begin
        bit lo_tc;
        lo_tc = tc_exp(m_lo, up, hold_n);
        if (clr) begin
            m_lo = 0; m_hi = 0;
        end else if (load) begin
            m_lo = pval; m_hi = hi_pval;
        end else begin
            if (!lo_tc) m_hi = step(m_hi, up);
            if (!hold_n) m_lo = step(m_lo, up);
        end
    end
    always @(posedge clr) begin m_lo = 0; m_hi = 0; end
    always @(negedge load) if (!clr) begin m_lo = pval; m_hi = hi_pval; end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(phase, lo_digit, shown(m_lo, pval));
            chk(phase, hi_digit, shown(m_hi, hi_pval));
            chk(phase, lo_tc_n, tc_exp(shown(m_lo, pval), up, hold_n));
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: clear overrides an active preset and the clock
        load = 1'b1; pval = 4'd7; hold_n = 1'b0;
        cycles(3);
        chk("R1", lo_digit, 0);
        cmp_on = 1'b1;
        load = 1'b0; hold_n = 1'b1;
        cycles(1);
        clr = 1'b0;
        cycles(2);
        chk("R1", lo_digit, 0);

        // R2: preset follows the value between edges and is kept after release
        phase = "R2";
        load = 1'b1; pval = 4'd3; #0.5;
        chk("R2", lo_digit, 3);
        pval = 4'd6; #0.5;
        chk("R2", lo_digit, 6);
        cycles(1);
        load = 1'b0; #0.5;
        chk("R2", lo_digit, 6);

        // R4: disabled counter keeps its digit
        phase = "R4";
        cycles(4);
        chk("R4", lo_digit, 6);

        // R3: enable alone does not move the digit between edges
        phase = "R3";
        hold_n = 1'b0; #0.5;
        chk("R3", lo_digit, 6);
        cycles(1);
        chk("R3", lo_digit, 7);

        // R5: up counting through the 9 -> 0 wrap
        phase = "R5";
        cycles(12);
        // R6: down counting through the 0 -> 9 wrap
        phase = "R6"; up = 1'b0;
        cycles(12);

        // R7: illegal digits
        phase = "R7";
        hold_n = 1'b1; up = 1'b1; load = 1'b1; pval = 4'd13;
        cycles(1);
        load = 1'b0; #0.5;
        chk("R8", lo_tc_n, 1);
        hold_n = 1'b0; #0.5;
        chk("R8", lo_tc_n, 0);
        cycles(1);
        chk("R7", lo_digit, 0);
        hold_n = 1'b1; up = 1'b0; load = 1'b1; pval = 4'd12;
        cycles(1);
        load = 1'b0; hold_n = 1'b0;
        cycles(1);
        chk("R7", lo_digit, 11);
        cycles(2);
        chk("R7", lo_digit, 9);

        // R8 / R9: terminal flag gated by the enable
        phase = "R8";
        hold_n = 1'b1; up = 1'b1; #0.5;
        chk("R8", lo_tc_n, 1);
        hold_n = 1'b0; #0.5;
        chk("R8", lo_tc_n, 0);
        cycles(1);
        phase = "R9"; up = 1'b0; #0.5;
        chk("R9", lo_tc_n, 0);
        hold_n = 1'b1; #0.5;
        chk("R9", lo_tc_n, 1);
        hold_n = 1'b0; up = 1'b1;
        cycles(3);

        // R1: clear in mid cycle while a preset is held
        phase = "R1";
        load = 1'b1; pval = 4'd5; #0.5;
        clr = 1'b1; #0.5;
        chk("R1", lo_digit, 0);
        load = 1'b0;
        cycles(2);

        // R10: two chained decades 00 -> 99 -> 00 and back down
        phase = "R10";
        hold_n = 1'b0; up = 1'b1; clr = 1'b0;
        cycles(99);
        chk("R10", hi_digit * 10 + lo_digit, 99);
        cycles(1);
        chk("R10", hi_digit * 10 + lo_digit, 0);
        up = 1'b0;
        cycles(1);
        chk("R10", hi_digit * 10 + lo_digit, 99);
        cycles(99);
        chk("R10", hi_digit * 10 + lo_digit, 0);

        cmp_on = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule